// File: doc/BRIEF.md
# NAND Flash Status Register Unit

This block is the device-side status logic of a NAND-style flash die. A command latch hands it one decoded command per cycle. From these commands it tracks two things: whether the die is in status-read mode, and whether a cache program is the operation in progress. It also keeps a sticky flag that records a failed program or erase.

The status byte is built from live inputs every cycle:

- the write-protect level;
- the busy flag of the program/erase/read controller;
- the busy flag of the cache register.

When the host reads with both chip-enable and read-enable low, the unit puts a value on the data output. In status-read mode that value is the status byte. Otherwise it is the page data from the array path.

Status-read mode lasts until the next command arrives. A page read therefore needs a fresh read command after a status poll. Because the byte is assembled combinationally from current conditions, a host can hold the enables low and watch the device go from busy to ready.

Top module: `nfsr_top`

## Requirements
- R1: While the reset input is low, and after it is released, the unit is out of status-read mode, the fail flag is 0 and the cache-program context is clear. Reset assertion takes effect at once; release takes effect after two clock edges.
- R2: A command with code 1 (read status) accepted on a clock edge puts the unit in status-read mode from that edge on. The mode persists through any number of cycles with no command.
- R3: A command with any other code (0 read, 2 program, 3 cache program, 4 erase, 5 to 7 other) leaves status-read mode on the edge that accepts it. Reads then return page data.
- R4: Status bit 7 is 1 when the write-protect input is 0 (program and erase allowed), and 0 when that input is 1.
- R5: Status bit 5 is the inverse of the controller busy input.
- R6: While the cache-program context is set, status bit 6 is the inverse of the cache busy input.
- R7: While the cache-program context is clear, status bit 6 is the inverse of the controller busy input.
- R8: A cache program command (code 3) sets the context. The context is cleared by any accepted command other than codes 3 and 1, or by an edge on which both busy inputs are 0. When a cache program command arrives on an edge where both busy inputs are 0, the set wins.
- R9: Status bit 0 is set by a cycle with the fail input high. It is cleared by an accepted program, cache program or erase command, and the command wins if both occur on the same edge.
- R10: The output enable is 1 only while chip-enable and read-enable are both low. When it is 0 the data output is all zeros.
- R11: With the enables held low, a change on the write-protect or busy inputs appears on the data output in the same cycle, with no enable toggle.
- R12: Status bits 4 to 1, and any bit above 7, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | A decoded command is present this cycle |
| cmd_code_i | input | 3 | Command code (see R2, R3) |
| wr_protect_i | input | 1 | 1 = device write protected |
| ctrl_busy_i | input | 1 | Program/erase/read controller busy |
| cache_busy_i | input | 1 | Cache register busy |
| op_fail_i | input | 1 | Pulse: last program or erase failed |
| ce_n_i | input | 1 | Chip-enable, active low |
| re_n_i | input | 1 | Read-enable, active low |
| page_data_i | input | DATA_W | Page data from the array path |
| dout_o | output | DATA_W | Data output value |
| dout_oe_o | output | 1 | Data output enable (0 = bus released) |

## Verification
The hardest state to reach from the ports is the one where bit 6 has to reflect the cache busy flag rather than the controller's. It needs a cache program, then a status command, which must not clear the context, with the two busy inputs set to opposite values. The opposite state is just as hard: the context must be shown to have cleared while the inputs still disagree. The stimulus table therefore idles both busy lines for one cycle, then raises only the controller busy so that bit 6 distinguishes a cleared context from a stale one. It also issues a cache program while both lines are idle, to show that the set has priority.

// File: rtl/nfsr_pkg.sv
`timescale 1ns/1ps
package nfsr_pkg;
  localparam int CMD_W = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_READ   = 3'd0,
    CMD_RDSTAT = 3'd1,
    CMD_PROG   = 3'd2,
    CMD_CPROG  = 3'd3,
    CMD_ERASE  = 3'd4,
    CMD_MISC   = 3'd5
  } cmd_e;

  // status byte bit positions (host software decodes these)
  localparam int SB_WP   = 7;
  localparam int SB_RDY6 = 6;
  localparam int SB_RDY5 = 5;
  localparam int SB_FAIL = 0;
  localparam int SB_W    = 8;
endpackage

// File: rtl/nfsr_rst_sync.sv
`timescale 1ns/1ps
module nfsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/nfsr_mode_track.sv
`timescale 1ns/1ps
module nfsr_mode_track
  import nfsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid_i,
  input  logic [CMD_W-1:0] cmd_code_i,
  input  logic             ctrl_busy_i,
  input  logic             cache_busy_i,
  input  logic             op_fail_i,
  output logic             status_mode_o,
  output logic             cache_ctx_o,
  output logic             fail_o
);
  logic mode_q, mode_d;
  logic ctx_q, ctx_d;
  logic fail_q, fail_d;
  logic is_stat, is_cprog, starts_op, both_idle, upd_en;

  always_comb begin
    is_stat   = cmd_valid_i && (cmd_code_i == CMD_RDSTAT);
    is_cprog  = cmd_valid_i && (cmd_code_i == CMD_CPROG);
    starts_op = cmd_valid_i && ((cmd_code_i == CMD_PROG) ||
                                (cmd_code_i == CMD_CPROG) ||
                                (cmd_code_i == CMD_ERASE));
    both_idle = !ctrl_busy_i && !cache_busy_i;

    mode_d = cmd_valid_i ? is_stat : mode_q;

    if (is_cprog)                  ctx_d = 1'b1;
    else if (cmd_valid_i && !is_stat) ctx_d = 1'b0;
    else if (both_idle)            ctx_d = 1'b0;
    else                           ctx_d = ctx_q;

    if (starts_op)      fail_d = 1'b0;
    else if (op_fail_i) fail_d = 1'b1;
    else                fail_d = fail_q;

    upd_en = cmd_valid_i || op_fail_i || (ctx_q && both_idle);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      ctx_q  <= 1'b0;
      fail_q <= 1'b0;
    end else if (upd_en) begin
      mode_q <= mode_d;
      ctx_q  <= ctx_d;
      fail_q <= fail_d;
    end
  end

  assign status_mode_o = mode_q;
  assign cache_ctx_o   = ctx_q;
  assign fail_o        = fail_q;
endmodule

// File: rtl/nfsr_status_build.sv
`timescale 1ns/1ps
module nfsr_status_build
  import nfsr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              wr_protect_i,
  input  logic              ctrl_busy_i,
  input  logic              cache_busy_i,
  input  logic              cache_ctx_i,
  input  logic              fail_i,
  output logic [DATA_W-1:0] status_o
);
  logic [SB_W-1:0] core;

  always_comb begin
    core          = '0;
    core[SB_WP]   = !wr_protect_i;
    core[SB_RDY6] = cache_ctx_i ? !cache_busy_i : !ctrl_busy_i;
    core[SB_RDY5] = !ctrl_busy_i;
    core[SB_FAIL] = fail_i;
  end

  generate
    if (DATA_W > SB_W) begin : g_wide
      assign status_o = {{(DATA_W-SB_W){1'b0}}, core};
    end else begin : g_exact
      assign status_o = core[DATA_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/nfsr_out_mux.sv
`timescale 1ns/1ps
module nfsr_out_mux #(
  parameter int DATA_W = 8
) (
  input  logic              ce_n_i,
  input  logic              re_n_i,
  input  logic              status_mode_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] page_data_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_oe_o
);
  always_comb begin
    dout_oe_o = !ce_n_i && !re_n_i;
    if (!dout_oe_o)         dout_o = '0;
    else if (status_mode_i) dout_o = status_i;
    else                    dout_o = page_data_i;
  end
endmodule

// File: rtl/nfsr_top.sv
`timescale 1ns/1ps
module nfsr_top
  import nfsr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_code_i,
  input  logic              wr_protect_i,
  input  logic              ctrl_busy_i,
  input  logic              cache_busy_i,
  input  logic              op_fail_i,
  input  logic              ce_n_i,
  input  logic              re_n_i,
  input  logic [DATA_W-1:0] page_data_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_oe_o
);
  logic              rst_sync_n;
  logic              status_mode_q;
  logic              cache_ctx_q;
  logic              fail_q;
  logic [DATA_W-1:0] status_byte;

  nfsr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  nfsr_mode_track u_mode (
    .clk(clk), .rst_n(rst_sync_n),
    .cmd_valid_i(cmd_valid_i), .cmd_code_i(cmd_code_i),
    .ctrl_busy_i(ctrl_busy_i), .cache_busy_i(cache_busy_i),
    .op_fail_i(op_fail_i),
    .status_mode_o(status_mode_q), .cache_ctx_o(cache_ctx_q), .fail_o(fail_q)
  );

  nfsr_status_build #(.DATA_W(DATA_W)) u_build (
    .wr_protect_i(wr_protect_i), .ctrl_busy_i(ctrl_busy_i),
    .cache_busy_i(cache_busy_i), .cache_ctx_i(cache_ctx_q),
    .fail_i(fail_q), .status_o(status_byte)
  );

  nfsr_out_mux #(.DATA_W(DATA_W)) u_out (
    .ce_n_i(ce_n_i), .re_n_i(re_n_i), .status_mode_i(status_mode_q),
    .status_i(status_byte), .page_data_i(page_data_i),
    .dout_o(dout_o), .dout_oe_o(dout_oe_o)
  );
endmodule

// File: rtl/nfsr_checks.sv
`timescale 1ns/1ps
module nfsr_checks
  import nfsr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid_i,
  input logic [2:0]        cmd_code_i,
  input logic              wr_protect_i,
  input logic              ctrl_busy_i,
  input logic              cache_busy_i,
  input logic              ce_n_i,
  input logic              re_n_i,
  input logic              status_mode,
  input logic              cache_ctx,
  input logic              fail,
  input logic [DATA_W-1:0] dout_o,
  input logic              dout_oe_o
);
  a_r2_enter_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_code_i == CMD_RDSTAT) |=> status_mode);

  a_r3_leave_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_code_i != CMD_RDSTAT) |=> !status_mode);

  a_r4_wp_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (status_mode && dout_oe_o) |-> (dout_o[SB_WP] == !wr_protect_i));

  a_r5_ctrl_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (status_mode && dout_oe_o) |-> (dout_o[SB_RDY5] == !ctrl_busy_i));

  a_r6_cache_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (status_mode && dout_oe_o && cache_ctx) |-> (dout_o[SB_RDY6] == !cache_busy_i));

  a_r7_ready_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (status_mode && dout_oe_o && !cache_ctx) |-> (dout_o[SB_RDY6] == !ctrl_busy_i));

  a_r8_cprog_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_code_i == CMD_CPROG) |=> cache_ctx);

  a_r9_fail_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && (cmd_code_i == CMD_PROG || cmd_code_i == CMD_CPROG ||
                     cmd_code_i == CMD_ERASE)) |=> !fail);

  a_r10_released: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n_i || re_n_i) |-> (!dout_oe_o && dout_o == '0));

  a_r12_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (status_mode && dout_oe_o) |-> (dout_o[4:1] == 4'b0));
endmodule

bind nfsr_top nfsr_checks #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .cmd_valid_i(cmd_valid_i), .cmd_code_i(cmd_code_i),
  .wr_protect_i(wr_protect_i), .ctrl_busy_i(ctrl_busy_i),
  .cache_busy_i(cache_busy_i), .ce_n_i(ce_n_i), .re_n_i(re_n_i),
  .status_mode(status_mode_q), .cache_ctx(cache_ctx_q), .fail(fail_q),
  .dout_o(dout_o), .dout_oe_o(dout_oe_o)
);

// File: tb/nfsr_top_test.sv
`timescale 1ns/1ps
module nfsr_top_test;
  logic       clk;
  logic       rst_n;
  logic       cmd_valid_i;
  logic [2:0] cmd_code_i;
  logic       wr_protect_i, ctrl_busy_i, cache_busy_i, op_fail_i;
  logic       ce_n_i, re_n_i;
  logic [7:0] page_data_i;
  logic [7:0] dout_o;
  logic       dout_oe_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  nfsr_top uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_code_i(cmd_code_i),
    .wr_protect_i(wr_protect_i), .ctrl_busy_i(ctrl_busy_i),
    .cache_busy_i(cache_busy_i), .op_fail_i(op_fail_i),
    .ce_n_i(ce_n_i), .re_n_i(re_n_i), .page_data_i(page_data_i),
    .dout_o(dout_o), .dout_oe_o(dout_oe_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // one row: inputs applied before an edge, outputs expected just after it
  typedef struct packed {
    logic       v;
    logic [2:0] cmd;
    logic       wp, cb, pb, fl, ce_n, re_n;
    logic [7:0] page;
    logic       e_oe;
    logic [7:0] e_dout;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 22;
  // cmd codes: 0 read, 1 status, 2 program, 3 cache program, 4 erase, 5 other
  localparam vec_t VECS [NV] = '{
    '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,8'hA5,1'b0,8'h00,8'd10}, // R10 idle bus
    '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'hA5,1'b1,8'hA5,8'd1},  // R1 page data after reset
    '{1'b1,3'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'hA5,1'b1,8'hE0,8'd2},  // R2 enter status, R12
    '{1'b0,3'd0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'hA5,1'b1,8'h60,8'd4},  // R4 protected
    '{1'b0,3'd0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'hA5,1'b1,8'h80,8'd11}, // R11 R5 R7 live busy
    '{1'b1,3'd2,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'h3C,1'b1,8'h3C,8'd3},  // R3 program exits mode
    '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h3C,1'b1,8'h3C,8'd3},  // R3 fail pulse, page shown
    '{1'b1,3'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h3C,1'b1,8'hE1,8'd9},  // R9 fail bit set
    '{1'b1,3'd3,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'h5A,1'b1,8'h5A,8'd3},  // R3 cache program
    '{1'b1,3'd1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'h5A,1'b1,8'hC0,8'd6},  // R6 cache ready, R9 cleared
    '{1'b0,3'd0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'h5A,1'b1,8'h80,8'd6},  // R6 cache busy
    '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h5A,1'b1,8'hE0,8'd5},  // R5 both idle
    '{1'b0,3'd0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'h5A,1'b1,8'h80,8'd8},  // R8 context cleared by idle
    '{1'b1,3'd3,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h11,1'b1,8'h11,8'd3},  // R3 cache prog while idle
    '{1'b1,3'd1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'h11,1'b1,8'hC0,8'd8},  // R8 set won over idle
    '{1'b1,3'd4,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,8'h22,1'b1,8'h22,8'd3},  // R3 erase with fail pulse
    '{1'b1,3'd1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'h22,1'b1,8'h80,8'd9},  // R9 command won, R8 cleared
    '{1'b0,3'd0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,8'h22,1'b0,8'h00,8'd10}, // R10 read-enable high
    '{1'b0,3'd0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,8'h22,1'b0,8'h00,8'd10}, // R10 chip-enable high
    '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h22,1'b1,8'hE0,8'd2},  // R2 mode persisted
    '{1'b1,3'd5,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h77,1'b1,8'h77,8'd3},  // R3 other command
    '{1'b1,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h77,1'b1,8'h77,8'd3}   // R3 read command
  };

  task automatic drive(input vec_t t);
    cmd_valid_i  = t.v;   cmd_code_i  = t.cmd;
    wr_protect_i = t.wp;  cache_busy_i = t.cb;
    ctrl_busy_i  = t.pb;  op_fail_i   = t.fl;
    ce_n_i       = t.ce_n; re_n_i     = t.re_n;
    page_data_i  = t.page;
  endtask

  task automatic check(input int req, input logic e_oe, input logic [7:0] e_dout);
    checks++;
    if (dout_oe_o !== e_oe || dout_o !== e_dout) begin
      fails++;
      $display("FAIL R%0d: oe=%0b dout=%02h expected oe=%0b dout=%02h",
               req, dout_oe_o, dout_o, e_oe, e_dout);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive('{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h5C,1'b0,8'h00,8'd0});
    repeat (3) @(posedge clk);
    #1 check(1, 1'b1, 8'h5C);                 // R1 page data while in reset
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(posedge clk);
      #1 check(int'(VECS[i].req), VECS[i].e_oe, VECS[i].e_dout);
    end

    // R1 mid-run reset: build status mode and fail, then reset asynchronously
    drive('{1'b0,3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h99,1'b0,8'h00,8'd0});
    @(posedge clk); #1;
    drive('{1'b1,3'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h99,1'b0,8'h00,8'd0});
    @(posedge clk); #1;
    drive('{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h99,1'b0,8'h00,8'd0});
    check(9, 1'b1, 8'hE1);                    // R9 fail visible before reset
    rst_n = 1'b0;
    #1 check(1, 1'b1, 8'h99);                 // R1 mode cleared at once
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    drive('{1'b1,3'd1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h99,1'b0,8'h00,8'd0});
    @(posedge clk);
    #1 check(1, 1'b1, 8'hE0);                 // R1 fail and context cleared, R7 bit 6
    drive('{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h99,1'b0,8'h00,8'd0});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule